// File: doc/BRIEF.md
# Configurable GPIO Port

This block is a parameterised general-purpose I/O port, sixteen pins wide by default. Software controls it over a simple register bus. A buffer register holds the value each pin should carry. A direction register sets each pin as an input or an output. An attribute register changes meaning with the direction: on an output it picks inverted or true drive, and on an input it picks a pull resistor or a floating pin. A mask register protects chosen buffer bits from writes.

The block does not model the pad cell itself. It drives a drive-enable, a drive value and pull-up and pull-down enables for each pin. It takes the pad's input level, which is asynchronous, and passes it through a two-flop synchronizer. Software can read that synchronized pin level and the internal buffer separately. Register addresses are: 0 pin level (read) or masked buffer write, 1 buffer, 2 direction, 3 attribute, 4 mask. Addresses 5 to 7 are unused.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, all registers hold 0. pad_oe is 0, pad_out is 0, pad_pull_up is 0 and pad_pull_dn is all ones.
- R2: pad_oe bit i equals direction bit i. A 1 means output and a 0 means input.
- R3: On an output pin whose attribute bit is 0, pad_out is the inverse of the buffer bit.
- R4: On an output pin whose attribute bit is 1, pad_out equals the buffer bit. pad_out is 0 on every input pin.
- R5: On an input pin whose attribute bit is 0, buffer bit 1 enables the pull-up and buffer bit 0 enables the pull-down. The two are never enabled together.
- R6: On an input pin whose attribute bit is 1, neither pull is enabled.
- R7: On an output pin, neither pull is enabled.
- R8: A write to address 0 or 1 changes only the buffer bits whose mask bit is 0. Buffer bits whose mask bit is 1 keep their value.
- R9: Writes to direction (address 2), attribute (address 3) and mask (address 4) load all bits, whatever the mask holds.
- R10: A read of address 0 returns pad_in through two synchronizer flops. A change of pad_in shows up in a read whose request edge comes at least three clock edges after the change. A read requested sooner returns the old level.
- R11: A read of address 1 returns the buffer, whatever the pin levels are.
- R12: A read returns its data on bus_rdata one clock after the request. Reads of addresses 5 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, registered |
| pad_in | input | WIDTH | Asynchronous pin levels from the pads |
| pad_out | output | WIDTH | Drive value for each pin |
| pad_oe | output | WIDTH | Drive enable for each pin |
| pad_pull_up | output | WIDTH | Pull-up enable for each pin |
| pad_pull_dn | output | WIDTH | Pull-down enable for each pin |

## Verification
The bench targets the dual meaning of the attribute bit, flipping direction under fixed attribute and buffer values. A design that decoded the attribute the same way in both directions would leave a pull active on a driven pin, or invert an input's pull choice. It writes the buffer through both write addresses under a partial mask, which catches a mask of the wrong polarity or a mask applied to other registers. It reads the pin level one cycle too early and then just in time, which exposes a synchronizer with a stage missing or added. It also writes and reads the unused addresses, which catches a partial address decode that aliases onto a real register.

// File: rtl/gpio_port_pkg.sv
// Package: shared register address map for the GPIO port.
// Assumes a 3-bit register address; addresses beyond REG_MASK are unused.
package gpio_port_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] REG_PIN  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_BUF  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_DIR  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_ATTR = 3'd3;
    localparam logic [ADDR_W-1:0] REG_MASK = 3'd4;
endpackage

// File: rtl/gpio_regs.sv
// Module: control register file of the GPIO port.
// Holds buffer, direction, attribute and mask. Buffer writes (pin or buffer
// address) are gated by the mask; the other registers load fully.
// Assumes one write per cycle and a synchronous active-low reset.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  buf_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  attr_q,
    output logic [WIDTH-1:0]  mask_q
);

    // Register update: masked merge for buffer, plain load for the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            dir_q  <= '0;
            attr_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_PIN, REG_BUF: buf_q <= (buf_q & mask_q) | (wdata & ~mask_q);
                REG_DIR:          dir_q  <= wdata;
                REG_ATTR:         attr_q <= wdata;
                REG_MASK:         mask_q <= wdata;
                default:          ;
            endcase
        end
    end

    // R8: protected buffer bits survive a buffer write
    a_r8_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == REG_PIN || wr_addr == REG_BUF))
        |=> ((buf_q & $past(mask_q)) == ($past(buf_q) & $past(mask_q))));

    // R9: direction loads every bit regardless of mask
    a_r9_dir_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIR) |=> (dir_q == $past(wdata)));

endmodule

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pin levels.
// Each bit passes through STAGES flops; no bits are correlated.
// Assumes STAGES >= 1 and a synchronous active-low reset.
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Later stages shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: per-pin pad control decode.
// Attribute means true/inverted drive on outputs and float/pull on inputs;
// for pulled inputs the buffer bit picks up (1) or down (0).
// Assumes direction 1 = output. Purely combinational.
module gpio_pad_ctrl #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] buf_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] attr_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pull_up,
    output logic [WIDTH-1:0] pull_dn
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic pulled;
            // Pull only on inputs whose attribute asks for a resistor.
            assign pulled     = ~dir_q[i] & ~attr_q[i];
            assign pad_oe[i]  = dir_q[i];
            assign pad_out[i] = dir_q[i] & (attr_q[i] ? buf_q[i] : ~buf_q[i]);
            assign pull_up[i] = pulled &  buf_q[i];
            assign pull_dn[i] = pulled & ~buf_q[i];
        end
    endgenerate

endmodule

// File: rtl/gpio_port.sv
// Module: GPIO port top. Connects the register file, the pin synchronizer
// and the pad decode, and returns register or pin data one cycle after a
// read request. Assumes single-cycle bus accesses and active-low sync reset.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pull_up,
    output logic [WIDTH-1:0]  pad_pull_dn
);

    localparam int SYNC_STAGES = 2;

    logic [WIDTH-1:0] buf_q, dir_q, attr_q, mask_q, pin_q;
    logic             wr_en, rd_en;

    assign wr_en = bus_sel &  bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(bus_addr),
        .wdata  (bus_wdata),
        .buf_q  (buf_q),
        .dir_q  (dir_q),
        .attr_q (attr_q),
        .mask_q (mask_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pin_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) i_pad (
        .buf_q  (buf_q),
        .dir_q  (dir_q),
        .attr_q (attr_q),
        .pad_out(pad_out),
        .pad_oe (pad_oe),
        .pull_up(pad_pull_up),
        .pull_dn(pad_pull_dn)
    );

    // Read path: capture the addressed source one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            case (bus_addr)
                REG_PIN:  bus_rdata <= pin_q;
                REG_BUF:  bus_rdata <= buf_q;
                REG_DIR:  bus_rdata <= dir_q;
                REG_ATTR: bus_rdata <= attr_q;
                REG_MASK: bus_rdata <= mask_q;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // Cycles since reset release, saturating, to qualify the latency check.
    logic [1:0] settle_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                 settle_cnt <= '0;
        else if (settle_cnt != 2'd3) settle_cnt <= settle_cnt + 2'd1;
    end

    // R2: drive enable follows the direction register
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == dir_q);

    // R5: pull-up and pull-down never on together
    a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_up & pad_pull_dn) == '0);

    // R7: driven pins carry no pull
    a_r7_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pull_up | pad_pull_dn)) == '0);

    // R10: synchronized level is the pin level two edges earlier
    a_r10_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_cnt == 2'd3) |-> (pin_q == $past(pad_in, 2)));

    // R12: unused addresses read as zero
    a_r12_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr > REG_MASK) |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_port.sv
// Bench for gpio_port: directed corners plus seeded random traffic,
// checked against a register model kept in the bench.
module test_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0, pad_in = '0;
    logic [W-1:0]  bus_rdata, pad_out, pad_oe, pad_pull_up, pad_pull_dn;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [W-1:0] m_buf = '0, m_dir = '0, m_attr = '0, m_mask = '0;
    logic [W-1:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.WIDTH(W)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
    );

    function automatic logic [W-1:0] f_out();
        return m_dir & ((m_attr & m_buf) | (~m_attr & ~m_buf));
    endfunction
    function automatic logic [W-1:0] f_up();
        return ~m_dir & ~m_attr & m_buf;
    endfunction
    function automatic logic [W-1:0] f_dn();
        return ~m_dir & ~m_attr & ~m_buf;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; updates the model.
    task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            3'd0, 3'd1: m_buf = (m_buf & m_mask) | (d & ~m_mask);
            3'd2: m_dir = d;
            3'd3: m_attr = d;
            3'd4: m_mask = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        check({req, " oe"},   pad_oe,      m_dir);
        check({req, " out"},  pad_out,     f_out());
        check({req, " up"},   pad_pull_up, f_up());
        check({req, " dn"},   pad_pull_dn, f_dn());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pad_oe, '0);
        check("R1 out", pad_out, '0);
        check("R1 up", pad_pull_up, '0);
        check("R1 dn", pad_pull_dn, '1);
        for (int a = 1; a < 5; a++) begin
            bus_read(3'(a), rd);
            check("R1 reg", rd, '0);
        end

        // R3: outputs, inverted drive
        bus_write(3'd2, 16'hFFFF);
        bus_write(3'd1, 16'h00FF);
        check("R3 out inverted", pad_out, 16'hFF00);
        check_pads("R7");
        // R4: outputs, true drive
        bus_write(3'd3, 16'hFFFF);
        check("R4 out true", pad_out, 16'h00FF);
        // R2/R4: half inputs
        bus_write(3'd2, 16'h0F0F);
        check("R2 oe", pad_oe, 16'h0F0F);
        check("R4 inputs low", pad_out, 16'h000F);
        // R6: floating inputs
        check("R6 up", pad_pull_up & ~m_dir, '0);
        check("R6 dn", pad_pull_dn & ~m_dir, '0);
        // R5: pulled inputs
        bus_write(3'd2, 16'h0000);
        bus_write(3'd3, 16'h0000);
        bus_write(3'd1, 16'hA5A5);
        check("R5 up", pad_pull_up, 16'hA5A5);
        check("R5 dn", pad_pull_dn, 16'h5A5A);

        // R8: masked buffer writes through both addresses
        bus_write(3'd4, 16'hFF00);
        bus_write(3'd1, 16'h0000);
        bus_read(3'd1, rd);
        check("R8 buf addr1", rd, 16'hA500);
        bus_write(3'd0, 16'hFFFF);
        bus_read(3'd1, rd);
        check("R8 buf addr0", rd, 16'hA5FF);
        // R9: mask does not touch other registers
        bus_write(3'd2, 16'h1234);
        bus_read(3'd2, rd);
        check("R9 dir", rd, 16'h1234);
        bus_write(3'd3, 16'h4321);
        bus_read(3'd3, rd);
        check("R9 attr", rd, 16'h4321);

        // R10: synchronizer latency; R11: buffer independent of pins
        pad_in = 16'hC3C3;
        repeat (4) @(negedge clk);
        pad_in = 16'h3C3C;
        @(negedge clk);
        bus_read(3'd0, rd);
        check("R10 early read old", rd, 16'hC3C3);
        bus_read(3'd0, rd);
        check("R10 pin new", rd, 16'h3C3C);
        bus_read(3'd1, rd);
        check("R11 buf", rd, m_buf);

        // R12: unused addresses
        bus_write(3'd5, 16'hFFFF);
        bus_write(3'd7, 16'hFFFF);
        bus_read(3'd6, rd);
        check("R12 read zero", rd, '0);
        bus_read(3'd1, rd); check("R12 buf kept", rd, m_buf);
        bus_read(3'd2, rd); check("R12 dir kept", rd, m_dir);
        bus_read(3'd3, rd); check("R12 attr kept", rd, m_attr);
        bus_read(3'd4, rd); check("R12 mask kept", rd, m_mask);
        check_pads("R12");

        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [W-1:0] d;
            a = 3'($urandom_range(0, 7));
            d = W'($urandom);
            if (a > 3'd4 && $urandom_range(0, 3) != 0) a = 3'($urandom_range(0, 4));
            pad_in = W'($urandom);
            bus_write(a, d);
            check_pads("R2");
            bus_read(3'd1, rd);
            check("R8 rand buf", rd, m_buf);
            if (i % 8 == 0) begin
                @(negedge clk);
                bus_read(3'd0, rd);
                check("R10 rand pin", rd, pad_in);
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule